// File: doc/BRIEF.md
# Dual-Port RAM With Semaphore Access Decode

A 4096 x 8 memory with two independent, equal ports (left and right) on one clock. Each port carries four active-low controls: a memory select, a semaphore select, a write strobe and an output enable. A decoder in each port turns them into one of seven operations: sleep, memory read, memory write, semaphore read, semaphore write, outputs off, or the illegal case where both selects are low.

Selecting the semaphore space reaches a bank of eight one-bit ownership latches shared by both ports. Software claims a shared resource by writing 0 to a latch and checks whether the claim succeeded by reading the latch back. It gives the resource up by writing 1. Read data is registered and appears one cycle after the read. A per-port valid output replaces a tri-state enable.

Top module: `dpram_sem`

## Requirements
- R1: After reset both ports show `dout` = 0 with `dout_vld` low, and all eight semaphores are free: a semaphore read returns 8'hFF on either port.
- R2: A memory write (mem_sel low, flag_sel high, wr low) stores `din` at `addr` on the clock edge. A memory read (mem_sel low, flag_sel high, wr high, out_en low) puts the stored word on `dout` in the next cycle with `dout_vld` high. A word written by one port can be read by the other port from the next cycle on. A read of that word in the same cycle as the write returns the previous content.
- R3: Port decode uses active-low selects. mem_sel low with flag_sel high addresses the memory, and mem_sel high with flag_sel low addresses the semaphores. wr low writes. wr high with out_en low reads.
- R4: With out_en high and wr high, a port does no read, and `dout_vld` is low in the next cycle. Whenever `dout_vld` is low, `dout` is 0.
- R5: With both selects high the port is asleep: no access, and `dout_vld` is low in the next cycle.
- R6: With both selects low, `illegal` is high in that same cycle. The port changes neither memory nor semaphores, and `dout_vld` is low in the next cycle.
- R7: In semaphore space only `addr[2:0]` picks the semaphore and `addr[11:3]` is ignored. Semaphore accesses never change memory contents.
- R8: A semaphore write uses only `din[0]`: 0 requests the semaphore, and 1 releases it or cancels a pending request.
- R9: A semaphore read returns 8'h00 if the reading port owns that semaphore and 8'hFF otherwise. The value is registered and appears in the next cycle.
- R10: A request to a free semaphore grants it. A request while the other port owns it stays pending. When the owner releases, a pending request from the other port takes ownership on that edge. Both ports never own the same semaphore.
- R11: If both ports request a free semaphore in the same cycle, the left port gets it.
- R12: If both ports write the same memory address in the same cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_mem_sel_ni | input | 1 | Left memory select, active low |
| l_flag_sel_ni | input | 1 | Left semaphore select, active low |
| l_wr_ni | input | 1 | Left write strobe, active low |
| l_out_en_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | 12 | Left word address |
| l_din_i | input | 8 | Left write data |
| l_dout_o | output | 8 | Left read data, 0 when not valid |
| l_dout_vld_o | output | 1 | Left read data valid |
| l_illegal_o | output | 1 | Left select conflict flag |
| r_mem_sel_ni | input | 1 | Right memory select, active low |
| r_flag_sel_ni | input | 1 | Right semaphore select, active low |
| r_wr_ni | input | 1 | Right write strobe, active low |
| r_out_en_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | 12 | Right word address |
| r_din_i | input | 8 | Right write data |
| r_dout_o | output | 8 | Right read data, 0 when not valid |
| r_dout_vld_o | output | 1 | Right read data valid |
| r_illegal_o | output | 1 | Right select conflict flag |

## Verification
Corrupt ownership latches cannot be seen directly. They show up one cycle after a semaphore read, when both ports read 8'h00 for the same index, or when a port that was refused reads 8'h00 before the owner releases. For that reason the bench reads both ports after every semaphore write. A wrong decode shows in the same cycle on `illegal`, or one cycle later as a stray `dout_vld`. A write that lands in the wrong place only shows when that word is next read back, so every write in the bench is followed by a read.

// File: rtl/dpram_sem_pkg.sv
`timescale 1ns/1ps
package dpram_sem_pkg;
  typedef enum logic [2:0] {
    OP_SLEEP,
    OP_MEM_RD,
    OP_MEM_WR,
    OP_SEM_RD,
    OP_SEM_WR,
    OP_HIZ,
    OP_BAD
  } port_op_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_MEM,
    SRC_SEM
  } out_src_e;

  localparam int unsigned N_PORTS = 2;
  localparam int unsigned PORT_L  = 0;
  localparam int unsigned PORT_R  = 1;
endpackage

// File: rtl/dpram_port_dec.sv
`timescale 1ns/1ps
module dpram_port_dec
  import dpram_sem_pkg::*;
(
  input  logic     mem_sel_ni,
  input  logic     flag_sel_ni,
  input  logic     wr_ni,
  input  logic     out_en_ni,
  output port_op_e op_o,
  output logic     bad_o
);
  always_comb begin
    unique case ({mem_sel_ni, flag_sel_ni})
      2'b00:   op_o = OP_BAD;
      2'b11:   op_o = OP_SLEEP;
      2'b01: begin
        if (!wr_ni)          op_o = OP_MEM_WR;
        else if (!out_en_ni) op_o = OP_MEM_RD;
        else                 op_o = OP_HIZ;
      end
      default: begin
        if (!wr_ni)          op_o = OP_SEM_WR;
        else if (!out_en_ni) op_o = OP_SEM_RD;
        else                 op_o = OP_HIZ;
      end
    endcase
  end

  assign bad_o = (op_o == OP_BAD);
endmodule

// File: rtl/dpram_array.sv
`timescale 1ns/1ps
module dpram_array #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic [1:0]                   we_i,
  input  logic [1:0]                   re_i,
  input  logic [1:0][ADDR_W-1:0]       addr_i,
  input  logic [1:0][DATA_W-1:0]       wdata_i,
  output logic [1:0][DATA_W-1:0]       rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q  [2];

  // right first so the left port wins a same-address collision
  always_ff @(posedge clk_i) begin
    if (we_i[1]) mem_q[addr_i[1]] <= wdata_i[1];
    if (we_i[0]) mem_q[addr_i[0]] <= wdata_i[0];
  end

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < 2; p++) begin
      if (re_i[p]) rd_q[p] <= mem_q[addr_i[p]];
    end
  end

  assign rdata_o[0] = rd_q[0];
  assign rdata_o[1] = rd_q[1];
endmodule

// File: rtl/dpram_sem_bank.sv
`timescale 1ns/1ps
module dpram_sem_bank #(
  parameter int unsigned SEM_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                wr_i,
  input  logic [1:0]                rd_i,
  input  logic [1:0][SEM_W-1:0]     idx_i,
  input  logic [1:0]                bit_i,
  output logic [1:0]                rd_bit_o,
  output logic [(1<<SEM_W)-1:0]     own_l_o,
  output logic [(1<<SEM_W)-1:0]     own_r_o
);
  localparam int unsigned N_SEM = 1 << SEM_W;

  logic [N_SEM-1:0] req_l_q, req_r_q, own_l_q, own_r_q;
  logic [N_SEM-1:0] req_l_d, req_r_d, own_l_d, own_r_d;
  logic [N_SEM-1:0] keep_l, keep_r;
  logic [1:0]       rd_bit_q;

  for (genvar i = 0; i < N_SEM; i++) begin : g_sem
    assign req_l_d[i] = (wr_i[0] && idx_i[0] == SEM_W'(i)) ? ~bit_i[0] : req_l_q[i];
    assign req_r_d[i] = (wr_i[1] && idx_i[1] == SEM_W'(i)) ? ~bit_i[1] : req_r_q[i];
    // current owner keeps it while its request stands; else left has priority
    assign keep_l[i]  = own_l_q[i] & req_l_d[i];
    assign keep_r[i]  = own_r_q[i] & req_r_d[i];
    assign own_l_d[i] = keep_l[i] | (~keep_r[i] & req_l_d[i]);
    assign own_r_d[i] = ~own_l_d[i] & (keep_r[i] | req_r_d[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_l_q <= '0;
      req_r_q <= '0;
      own_l_q <= '0;
      own_r_q <= '0;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      own_l_q <= own_l_d;
      own_r_q <= own_r_d;
    end
  end

  // read value latched so a later write by the other port cannot disturb it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bit_q <= '1;
    end else begin
      if (rd_i[0]) rd_bit_q[0] <= ~own_l_q[idx_i[0]];
      if (rd_i[1]) rd_bit_q[1] <= ~own_r_q[idx_i[1]];
    end
  end

  assign rd_bit_o = rd_bit_q;
  assign own_l_o  = own_l_q;
  assign own_r_o  = own_r_q;
endmodule

// File: rtl/dpram_sem.sv
`timescale 1ns/1ps
module dpram_sem
  import dpram_sem_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEM_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_mem_sel_ni,
  input  logic              l_flag_sel_ni,
  input  logic              l_wr_ni,
  input  logic              l_out_en_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_din_i,
  output logic [DATA_W-1:0] l_dout_o,
  output logic              l_dout_vld_o,
  output logic              l_illegal_o,
  input  logic              r_mem_sel_ni,
  input  logic              r_flag_sel_ni,
  input  logic              r_wr_ni,
  input  logic              r_out_en_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_din_i,
  output logic [DATA_W-1:0] r_dout_o,
  output logic              r_dout_vld_o,
  output logic              r_illegal_o
);
  localparam int unsigned N_SEM = 1 << SEM_W;

  logic [1:0]              mem_sel_n, flag_sel_n, wr_n, out_en_n;
  logic [1:0][ADDR_W-1:0]  addr_w;
  logic [1:0][DATA_W-1:0]  din_w, rdata_w, dout_w;
  logic [1:0][SEM_W-1:0]   sem_idx;
  logic [1:0]              mem_we, mem_re, sem_we, sem_re, sem_din;
  logic [1:0]              bad_w, vld_w, sem_bit;
  logic [N_SEM-1:0]        own_l_w, own_r_w;
  port_op_e                op_w  [2];
  out_src_e                src_q [2];

  assign mem_sel_n  = {r_mem_sel_ni,  l_mem_sel_ni};
  assign flag_sel_n = {r_flag_sel_ni, l_flag_sel_ni};
  assign wr_n       = {r_wr_ni,       l_wr_ni};
  assign out_en_n   = {r_out_en_ni,   l_out_en_ni};
  assign addr_w     = {r_addr_i,      l_addr_i};
  assign din_w      = {r_din_i,       l_din_i};

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    dpram_port_dec u_dec (
      .mem_sel_ni  (mem_sel_n[p]),
      .flag_sel_ni (flag_sel_n[p]),
      .wr_ni       (wr_n[p]),
      .out_en_ni   (out_en_n[p]),
      .op_o        (op_w[p]),
      .bad_o       (bad_w[p])
    );

    assign mem_we[p]  = (op_w[p] == OP_MEM_WR);
    assign mem_re[p]  = (op_w[p] == OP_MEM_RD);
    assign sem_we[p]  = (op_w[p] == OP_SEM_WR);
    assign sem_re[p]  = (op_w[p] == OP_SEM_RD);
    assign sem_idx[p] = addr_w[p][SEM_W-1:0];
    assign sem_din[p] = din_w[p][0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        src_q[p] <= SRC_NONE;
      else if (mem_re[p]) src_q[p] <= SRC_MEM;
      else if (sem_re[p]) src_q[p] <= SRC_SEM;
      else                src_q[p] <= SRC_NONE;
    end

    always_comb begin
      unique case (src_q[p])
        SRC_MEM: dout_w[p] = rdata_w[p];
        SRC_SEM: dout_w[p] = {DATA_W{sem_bit[p]}};
        default: dout_w[p] = '0;
      endcase
    end

    assign vld_w[p] = (src_q[p] != SRC_NONE);
  end

  dpram_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .re_i    (mem_re),
    .addr_i  (addr_w),
    .wdata_i (din_w),
    .rdata_o (rdata_w)
  );

  dpram_sem_bank #(
    .SEM_W (SEM_W)
  ) u_sem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (sem_we),
    .rd_i     (sem_re),
    .idx_i    (sem_idx),
    .bit_i    (sem_din),
    .rd_bit_o (sem_bit),
    .own_l_o  (own_l_w),
    .own_r_o  (own_r_w)
  );

  assign l_dout_o     = dout_w[PORT_L];
  assign l_dout_vld_o = vld_w[PORT_L];
  assign l_illegal_o  = bad_w[PORT_L];
  assign r_dout_o     = dout_w[PORT_R];
  assign r_dout_vld_o = vld_w[PORT_R];
  assign r_illegal_o  = bad_w[PORT_R];
endmodule

// File: rtl/dpram_sem_chk.sv
`timescale 1ns/1ps
module dpram_sem_chk #(
  parameter int unsigned SEM_N  = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             mem_sel_n,
  input logic [1:0]             flag_sel_n,
  input logic [1:0]             wr_n,
  input logic [1:0]             out_en_n,
  input logic [1:0]             vld,
  input logic [1:0]             bad,
  input logic [1:0][DATA_W-1:0] dout,
  input logic [SEM_N-1:0]       own_l,
  input logic [SEM_N-1:0]       own_r
);
  for (genvar p = 0; p < 2; p++) begin : g_chk
    a_r4_oe_blocks_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_en_n[p] |=> !vld[p]);

    a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld[p] |-> dout[p] == '0);

    a_r5_sleep_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_sel_n[p] && flag_sel_n[p]) |=> !vld[p]);

    a_r6_bad_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad[p] |=> !vld[p]);

    a_r6_bad_only_on_conflict: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad[p] |-> (!mem_sel_n[p] && !flag_sel_n[p]));

    a_r9_sem_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_sel_n[p] && !flag_sel_n[p] && wr_n[p] && !out_en_n[p])
        |=> (vld[p] && (dout[p] == '0 || dout[p] == '1)));
  end

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);

  a_r6_no_sem_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad[0] && bad[1]) |=> ($stable(own_l) && $stable(own_r)));
endmodule

bind dpram_sem dpram_sem_chk #(
  .SEM_N  (N_SEM),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_sel_n  (mem_sel_n),
  .flag_sel_n (flag_sel_n),
  .wr_n       (wr_n),
  .out_en_n   (out_en_n),
  .vld        (vld_w),
  .bad        (bad_w),
  .dout       (dout_w),
  .own_l      (own_l_w),
  .own_r      (own_r_w)
);

// File: tb/dpram_sem_bench.sv
`timescale 1ns/1ps
module dpram_sem_bench;
  typedef struct packed {
    logic        mem_n;
    logic        flag_n;
    logic        wr_n;
    logic        oe_n;
    logic [11:0] addr;
    logic [7:0]  din;
  } cmd_t;

  typedef struct {
    logic       lv;
    logic [7:0] ld;
    logic       rv;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  cmd_t lc, rc;
  logic [7:0] l_dout, r_dout;
  logic l_vld, r_vld, l_bad, r_bad;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t exp_q[$];

  dpram_sem u_dpram_sem (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .l_mem_sel_ni  (lc.mem_n),
    .l_flag_sel_ni (lc.flag_n),
    .l_wr_ni       (lc.wr_n),
    .l_out_en_ni   (lc.oe_n),
    .l_addr_i      (lc.addr),
    .l_din_i       (lc.din),
    .l_dout_o      (l_dout),
    .l_dout_vld_o  (l_vld),
    .l_illegal_o   (l_bad),
    .r_mem_sel_ni  (rc.mem_n),
    .r_flag_sel_ni (rc.flag_n),
    .r_wr_ni       (rc.wr_n),
    .r_out_en_ni   (rc.oe_n),
    .r_addr_i      (rc.addr),
    .r_din_i       (rc.din),
    .r_dout_o      (r_dout),
    .r_dout_vld_o  (r_vld),
    .r_illegal_o   (r_bad)
  );

  function automatic cmd_t c_idle();
    return '{mem_n:1'b1, flag_n:1'b1, wr_n:1'b1, oe_n:1'b1, addr:12'h0, din:8'h0};
  endfunction
  function automatic cmd_t c_mrd(logic [11:0] a);
    return '{mem_n:1'b0, flag_n:1'b1, wr_n:1'b1, oe_n:1'b0, addr:a, din:8'h0};
  endfunction
  function automatic cmd_t c_mwr(logic [11:0] a, logic [7:0] d);
    return '{mem_n:1'b0, flag_n:1'b1, wr_n:1'b0, oe_n:1'b1, addr:a, din:d};
  endfunction
  function automatic cmd_t c_srd(logic [11:0] a);
    return '{mem_n:1'b1, flag_n:1'b0, wr_n:1'b1, oe_n:1'b0, addr:a, din:8'h0};
  endfunction
  function automatic cmd_t c_swr(logic [11:0] a, logic [7:0] d);
    return '{mem_n:1'b1, flag_n:1'b0, wr_n:1'b0, oe_n:1'b1, addr:a, din:d};
  endfunction
  function automatic cmd_t c_hiz(logic flag_space, logic [11:0] a);
    return '{mem_n:flag_space, flag_n:~flag_space, wr_n:1'b1, oe_n:1'b1, addr:a, din:8'h0};
  endfunction
  function automatic cmd_t c_bad(logic w_n, logic [11:0] a, logic [7:0] d);
    return '{mem_n:1'b0, flag_n:1'b0, wr_n:w_n, oe_n:1'b0, addr:a, din:d};
  endfunction

  task automatic check(string tag, string what, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus on both ports, expectation queued for the monitor
  task automatic step(cmd_t l, cmd_t r, logic lv, logic [7:0] ld,
                      logic rv, logic [7:0] rd, string tag);
    exp_t e;
    @(negedge clk);
    lc = l;
    rc = r;
    e.lv = lv; e.ld = ld; e.rv = rv; e.rd = rd; e.tag = tag;
    exp_q.push_back(e);
    #1;
    check(tag, "left illegal",  {8'h0, l_bad}, {8'h0, (!l.mem_n && !l.flag_n)});
    check(tag, "right illegal", {8'h0, r_bad}, {8'h0, (!r.mem_n && !r.flag_n)});
  endtask

  // monitor: results appear after the edge that captures the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "left data",  {l_vld, l_dout}, {e.lv, e.ld});
        check(e.tag, "right data", {r_vld, r_dout}, {e.rv, e.rd});
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    lc = c_idle();
    rc = c_idle();
    repeat (3) @(posedge clk);
    #1;
    check("R1", "left after reset",  {l_vld, l_dout}, 9'h000);
    check("R1", "right after reset", {r_vld, r_dout}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: semaphores free out of reset
    step(c_srd(12'h001), c_srd(12'h006), 1, 8'hFF, 1, 8'hFF, "R1");
    // R2 / R3: basic write and cross-port read
    step(c_mwr(12'h123, 8'h3C), c_mwr(12'hFFF, 8'hA5), 0, 8'h00, 0, 8'h00, "R3");
    step(c_mrd(12'hFFF), c_mrd(12'h123), 1, 8'hA5, 1, 8'h3C, "R2");
    // R2: same-cycle read sees old data, next cycle sees new
    step(c_mwr(12'h010, 8'h11), c_idle(), 0, 8'h00, 0, 8'h00, "R2");
    step(c_mwr(12'h010, 8'h22), c_mrd(12'h010), 0, 8'h00, 1, 8'h11, "R2");
    step(c_idle(), c_mrd(12'h010), 0, 8'h00, 1, 8'h22, "R2");
    // R4: output enable high blocks reads in both spaces
    step(c_hiz(1'b0, 12'h010), c_hiz(1'b1, 12'h003), 0, 8'h00, 0, 8'h00, "R4");
    // R6: conflicting selects do nothing
    step(c_bad(1'b0, 12'h123, 8'hFF), c_bad(1'b1, 12'h010, 8'h00), 0, 8'h00, 0, 8'h00, "R6");
    step(c_mrd(12'h123), c_mrd(12'h010), 1, 8'h3C, 1, 8'h22, "R6");
    // R7 setup: memory word at the semaphore's address
    step(c_mwr(12'h003, 8'h77), c_idle(), 0, 8'h00, 0, 8'h00, "R7");
    step(c_srd(12'hAB3), c_srd(12'h003), 1, 8'hFF, 1, 8'hFF, "R1");
    // R8: only bit 0 counts (0xFE requests)
    step(c_swr(12'hAB3, 8'hFE), c_idle(), 0, 8'h00, 0, 8'h00, "R8");
    step(c_srd(12'h003), c_srd(12'h5A3), 1, 8'h00, 1, 8'hFF, "R9");
    // R10: right request while left owns stays pending
    step(c_idle(), c_swr(12'h003, 8'h00), 0, 8'h00, 0, 8'h00, "R10");
    step(c_srd(12'h003), c_srd(12'h003), 1, 8'h00, 1, 8'hFF, "R10");
    // R10: left releases, right takes over
    step(c_swr(12'hAB3, 8'h01), c_idle(), 0, 8'h00, 0, 8'h00, "R10");
    step(c_srd(12'h003), c_srd(12'h003), 1, 8'hFF, 1, 8'h00, "R10");
    step(c_swr(12'h003, 8'h00), c_idle(), 0, 8'h00, 0, 8'h00, "R10");
    step(c_srd(12'h003), c_srd(12'h003), 1, 8'hFF, 1, 8'h00, "R10");
    // R7: upper address bits ignored on release
    step(c_idle(), c_swr(12'h7F3, 8'h01), 0, 8'h00, 0, 8'h00, "R7");
    step(c_srd(12'h003), c_srd(12'h003), 1, 8'h00, 1, 8'hFF, "R10");
    step(c_swr(12'h003, 8'hFF), c_idle(), 0, 8'h00, 0, 8'h00, "R8");
    step(c_srd(12'h003), c_srd(12'h003), 1, 8'hFF, 1, 8'hFF, "R8");
    // R11: simultaneous requests, left wins
    step(c_swr(12'h005, 8'h00), c_swr(12'hFFD, 8'h00), 0, 8'h00, 0, 8'h00, "R11");
    step(c_srd(12'h005), c_srd(12'h00D), 1, 8'h00, 1, 8'hFF, "R11");
    step(c_srd(12'h003), c_srd(12'h003), 1, 8'hFF, 1, 8'hFF, "R7");
    step(c_mrd(12'h003), c_idle(), 1, 8'h77, 0, 8'h00, "R7");
    // R6: conflicting selects cannot release a semaphore
    step(c_bad(1'b0, 12'h005, 8'h01), c_idle(), 0, 8'h00, 0, 8'h00, "R6");
    step(c_srd(12'h005), c_srd(12'h005), 1, 8'h00, 1, 8'hFF, "R6");
    // R12: same-address writes, left data stored
    step(c_mwr(12'h200, 8'hC3), c_mwr(12'h200, 8'h3C), 0, 8'h00, 0, 8'h00, "R12");
    step(c_mrd(12'h200), c_mrd(12'h200), 1, 8'hC3, 1, 8'hC3, "R12");
    // R5: both selects high
    step(c_idle(), c_idle(), 0, 8'h00, 0, 8'h00, "R5");
    step(c_idle(), c_idle(), 0, 8'h00, 0, 8'h00, "R5");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule